// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for each beat of a four-beat burst. A starting address is captured whenever the advance input is low. While the advance input is high, each clock step moves a two-bit beat index forward. The low two bits of the output address are worked out from the captured start and the beat index. The upper bits are passed through unchanged from the captured start.

Two beat orders are available, chosen by a static order-select input. Linear order counts upward from the start and wraps modulo four. Interleaved order XORs the start with the beat index. A stall input freezes all state for as long as it is held high. The output feeds the address path of a synchronous burst memory.

Top module: `burst_seq`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released, `addr_o` is 0 and `beat_o` is 0.
- R2: On a rising edge with `stall_i`=0 and `adv_i`=0, `addr_i` is captured as the burst start. From the next cycle, `beat_o`=0 and `addr_o` equals the captured address. This also holds when the capture happens in the middle of a burst.
- R3: On a rising edge with `stall_i`=0 and `adv_i`=1, `beat_o` goes up by one modulo 4, so beat 3 is followed by beat 0. `addr_i` is ignored on such edges.
- R4: With `ileave_i`=0 (linear order), `addr_o[1:0]` = (start[1:0] + `beat_o`) mod 4. For example, start 2 gives 2,3,0,1.
- R5: With `ileave_i`=1 (interleaved order), `addr_o[1:0]` = start[1:0] XOR `beat_o`. For example, start 1 gives 1,0,3,2.
- R6: `addr_o[ADDR_W-1:2]` stays equal to the captured start for the whole burst, including across wraps.
- R7: On an edge with `stall_i`=1, `beat_o` and the captured start keep their values, whatever `adv_i` and `addr_i` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stall_i | input | 1 | High freezes all state |
| adv_i | input | 1 | Low captures a new start; high advances the beat |
| ileave_i | input | 1 | Order select: 1 = interleaved, 0 = linear; held static |
| addr_i | input | ADDR_W | Start address to capture |
| addr_o | output | ADDR_W | Current beat address |
| beat_o | output | BEAT_W | Current beat index |

## Verification
Full bursts are run from all four low-bit start values in both orders. Starts 0 and 2 give the same sequence in both orders, while starts 1 and 3 differ between them, so those two starts separate an adder fault from an XOR fault. Runs of eight beats exercise the wrap and show that the upper bits stay unchanged across it. A capture in the middle of a burst, and stalled edges that carry both a capture request and an advance request, show that the beat resets on a capture and that a stall blocks every update.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;
endpackage

// File: rtl/burst_seq_ctr.sv
module burst_seq_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  output logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     beat_o <= '0;
    else if (en_i) begin
      if (load_i)    beat_o <= '0;
      else           beat_o <= beat_o + ONE; // wraps modulo 2**BEAT_W
    end
  end
endmodule

// File: rtl/burst_seq_base.sv
module burst_seq_base #(
  parameter int ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                base_o <= '0;
    else if (en_i && load_i)    base_o <= addr_i;
  end
endmodule

// File: rtl/burst_seq_order.sv
module burst_seq_order
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  input  order_e            order_i,
  output logic [BEAT_W-1:0] low_o
);
  logic [BEAT_W-1:0] lin_w;
  logic [BEAT_W-1:0] ilv_w;

  assign lin_w = start_i + beat_i;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_ilv
    assign ilv_w[b] = start_i[b] ^ beat_i[b];
  end

  always_comb begin
    unique case (order_i)
      ORD_INTERLEAVE: low_o = ilv_w;
      default:        low_o = lin_w;
    endcase
  end
endmodule

// File: rtl/burst_seq.sv
module burst_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic              adv_i,
  input  logic              ileave_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              en_w;
  logic              load_w;
  logic [ADDR_W-1:0] base_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] low_w;

  assign en_w   = ~stall_i;
  assign load_w = ~adv_i;

  burst_seq_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .load_i (load_w),
    .beat_o (beat_q)
  );

  burst_seq_base #(.ADDR_W(ADDR_W)) u_base (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_w),
    .load_i (load_w),
    .addr_i (addr_i),
    .base_o (base_q)
  );

  burst_seq_order #(.BEAT_W(BEAT_W)) u_order (
    .start_i (base_q[BEAT_W-1:0]),
    .beat_i  (beat_q),
    .order_i (order_e'(ileave_i)),
    .low_o   (low_w)
  );

  assign addr_o = {base_q[ADDR_W-1 -: HI_W], low_w};
  assign beat_o = beat_q;
endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              stall_i,
  input logic              adv_i,
  input logic              ileave_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [BEAT_W-1:0] beat_o
);
  localparam logic [BEAT_W-1:0] ONE = BEAT_W'(1);

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0 && beat_o == '0));

  a_r2_load_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && !adv_i) |=> (beat_o == '0 && addr_o == $past(addr_i)));

  a_r3_beat_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i) |=> (beat_o == $past(beat_o) + ONE));

  a_r4_linear_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && !ileave_i) |=>
      (ileave_i || addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + ONE));

  a_r5_ilv_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i && ileave_i) |=>
      (!ileave_i || (addr_o[BEAT_W-1:0] ^ beat_o) == $past(addr_o[BEAT_W-1:0] ^ beat_o)));

  a_r6_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_i && adv_i) |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  a_r7_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> ($stable(beat_o) && (!$stable(ileave_i) || $stable(addr_o))));
endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stall_i  (stall_i),
  .adv_i    (adv_i),
  .ileave_i (ileave_i),
  .addr_i   (addr_i),
  .addr_o   (addr_o),
  .beat_o   (beat_o)
);

// File: tb/burst_seq_tb.sv
module burst_seq_tb_top;
  localparam int ADDR_W = 20;
  localparam int BEAT_W = 2;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              stall_i = 1'b0;
  logic              adv_i = 1'b0;
  logic              ileave_i = 1'b0;
  logic [ADDR_W-1:0] addr_i = '0;
  logic [ADDR_W-1:0] addr_o;
  logic [BEAT_W-1:0] beat_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  burst_seq #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .stall_i(stall_i), .adv_i(adv_i),
    .ileave_i(ileave_i), .addr_i(addr_i), .addr_o(addr_o), .beat_o(beat_o)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step(logic st, logic adv, logic [ADDR_W-1:0] a);
    @(negedge clk_i);
    stall_i = st; adv_i = adv; addr_i = a;
    @(posedge clk_i);
    #1;
  endtask

  function automatic logic [1:0] exp_low(logic [1:0] s, logic [1:0] b, logic il);
    return il ? (s ^ b) : (s + b);
  endfunction

  task automatic t_reset();
    check("R1 addr", 32'(addr_o), 32'h0);
    check("R1 beat", 32'(beat_o), 32'h0);
  endtask

  task automatic t_burst(logic [ADDR_W-1:0] start, logic il, int nb);
    ileave_i = il;
    step(1'b0, 1'b0, start);
    check("R2 load addr", 32'(addr_o), 32'(start));
    check("R2 load beat", 32'(beat_o), 32'h0);
    for (int k = 1; k <= nb; k++) begin
      step(1'b0, 1'b1, ~start);  // addr_i ignored while advancing
      check("R3 beat", 32'(beat_o), 32'(k % 4));
      check(il ? "R5 ilv low" : "R4 lin low", 32'(addr_o[1:0]),
            32'(exp_low(start[1:0], 2'(k % 4), il)));
      check("R6 upper", 32'(addr_o[ADDR_W-1:2]), 32'(start[ADDR_W-1:2]));
    end
  endtask

  task automatic t_stall();
    ileave_i = 1'b0;
    step(1'b0, 1'b0, 20'h5A5A5);
    step(1'b0, 1'b1, '0);
    step(1'b1, 1'b0, 20'h12340);   // capture request while stalled
    check("R7 beat held load", 32'(beat_o), 32'h1);
    check("R7 addr held load", 32'(addr_o), 32'h5A5A6);
    step(1'b1, 1'b1, 20'h12340);   // advance request while stalled
    check("R7 beat held adv", 32'(beat_o), 32'h1);
    check("R7 addr held adv", 32'(addr_o), 32'h5A5A6);
    step(1'b0, 1'b1, '0);
    check("R7 resume beat", 32'(beat_o), 32'h2);
    check("R7 resume addr", 32'(addr_o), 32'h5A5A7);
  endtask

  task automatic t_reload();
    ileave_i = 1'b1;
    step(1'b0, 1'b0, 20'hF00F3);
    step(1'b0, 1'b1, '0);
    step(1'b0, 1'b1, '0);
    check("R5 mid", 32'(addr_o), 32'hF00F1);
    step(1'b0, 1'b0, 20'h0BEE1);
    check("R2 reload beat", 32'(beat_o), 32'h0);
    check("R2 reload addr", 32'(addr_o), 32'h0BEE1);
    step(1'b0, 1'b1, '0);
    check("R5 after reload", 32'(addr_o), 32'h0BEE0);
  endtask

  initial begin
    #1;
    t_reset();
    #20;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i);
    #1;
    t_reset();
    for (int s = 0; s < 4; s++) begin
      t_burst(20'hC3A50 | ADDR_W'(s), 1'b0, 8);
      t_burst(20'h3C5A0 | ADDR_W'(s), 1'b1, 8);
    end
    t_stall();
    t_reload();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule